// File: doc/BRIEF.md
# Debug System Bus Access Unit

This block is the part of a debug module that lets an external debugger read and write system memory. The debugger sends register requests over the debug module interface: a 6-bit register index, a read or write flag and a 32-bit write word. Every request gets a response one cycle later. The unit keeps a bus control/status register, an address register and a data register. It turns accesses to those registers into single-word reads and writes on a valid/ready bus master port. It also holds a one-bit module control register and a fixed identification status word.

A write to the data register stores the word and starts a bus write. When read prefetch on address write is enabled, writing the address register starts a bus read. When read prefetch on data read is enabled, reading the data register returns the word already fetched and then starts a read of the next word. With auto-increment enabled, the address advances by one word after each successful transfer.

Two error conditions are reported:
- Touching the address or data register while a transfer is in flight raises a sticky busy-error flag.
- A bus error response or an unsupported access size sets a sticky error code.

While either flag is set, no new transfer starts. Software clears each flag by writing 1 to its bits.

The sequencer has three states:
- IDLE, with no transfer.
- RD_REQ, a read request is held on the bus.
- WR_REQ, a write request is held on the bus.

It has four transitions:
- IDLE→WR_REQ on a data write.
- IDLE→RD_REQ on a prefetch trigger.
- RD_REQ→IDLE when the bus answers with ready.
- WR_REQ→IDLE when the bus answers with ready.

Top module: `dbg_sysbus_unit`

## Requirements
- R1: Index 0x10 is the control register: bit 0 is the active flag, it reads back the value written and is 0 after reset. Index 0x11 reads the constant parameter STATUS_WORD (default 0x00000082).
- R2: Index 0x38 is the bus control/status register. Its fields are: version in bits 31:29 (reads 1), busy-error in bit 22, busy in bit 21, prefetch-on-address in bit 20, access size in bits 19:17, auto-increment in bit 16, prefetch-on-data in bit 15, error code in bits 14:12, address width in bits 11:5 (reads ADDR_W), and bit 2, which reads 1 (word access supported). It reads 0x20040404 after reset. With no flags set, writing 0x20050404 or 0x20158404 reads back the same word.
- R3: A write to the data register (index 0x3C) while idle and error-free stores the word and raises mem_valid with mem_write=1, the address register value and that word. It holds all of them stable until mem_ready, and never has more than one request outstanding.
- R4: With auto-increment on, the address register grows by 4 after each successful transfer, so consecutive data writes after setting the address to 0 go to 0, 4, 8, 12, 16. With it off, the address is unchanged.
- R5: With prefetch-on-address on, writing the address register (index 0x39) starts a bus read at the written address, and the returned word is loaded into the data register.
- R6: With prefetch-on-data on, a data register read returns the word fetched earlier and then starts a read at the advanced address.
- R7: Bit 21 reads 1 while a bus request is outstanding.
- R8: An address write, data write or data read while busy is ignored and sets bit 22. While bit 22 is set, no transfer starts. Writing 1 to bit 22 clears it.
- R9: A bus error response sets the error code to 2 and leaves the address unchanged. While the code is nonzero, no transfer starts. Writing 1s to bits 14:12 clears it.
- R10: A transfer attempted with an access size other than 2 issues no bus request and sets the error code to 4.
- R11: Writing the control register with bit 0 clear returns the control, bus control/status, address and data registers to their reset values.
- R12: rsp_valid is high exactly one cycle after each cycle with dmi_valid high. A read of an unmapped index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmi_valid | input | 1 | Register request present this cycle |
| dmi_write | input | 1 | 1 = register write, 0 = register read |
| dmi_addr | input | 6 | Register index |
| dmi_wdata | input | 32 | Register write word |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read word of the response (0 for writes) |
| mem_valid | output | 1 | Bus request held until accepted |
| mem_write | output | 1 | 1 = bus write, 0 = bus read |
| mem_addr | output | ADDR_W | Bus byte address |
| mem_wdata | output | 32 | Bus write word |
| mem_ready | input | 1 | Bus completes the request |
| mem_rdata | input | 32 | Bus read word, valid with mem_ready |
| mem_err | input | 1 | Bus error, valid with mem_ready |

## Verification
Write and prefetch-read bursts of five words are each repeated with bus answer latencies of 0 to 3 cycles. This separates a correct hold-until-ready handshake from one that relies on an immediate answer, and an address that steps once per completion from one that steps per request. Starting the prefetch bursts at four different base addresses shows that the address comes from the register and not from a counter. A long-latency transfer, overlapped with address, data and status accesses, separates requests that are ignored while busy from requests that slip through. A transfer to an unmapped bus address and a transfer with a bad access size separate the two error codes and confirm that the error blocks later transfers until the error is cleared.

// File: rtl/dbg_sba_pkg.sv
package dbg_sba_pkg;

    localparam int DMI_AW = 6;
    localparam int WORD_W = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    localparam logic [DMI_AW-1:0] IDX_CTRL   = 6'h10;
    localparam logic [DMI_AW-1:0] IDX_STATUS = 6'h11;
    localparam logic [DMI_AW-1:0] IDX_BUSCS  = 6'h38;
    localparam logic [DMI_AW-1:0] IDX_ADDR   = 6'h39;
    localparam logic [DMI_AW-1:0] IDX_DATA   = 6'h3C;

    localparam logic [2:0] FMT_VERSION = 3'd1;
    localparam logic [2:0] SIZE_WORD   = 3'd2;
    localparam logic [2:0] ERR_NONE    = 3'd0;
    localparam logic [2:0] ERR_BUS     = 3'd2;
    localparam logic [2:0] ERR_SIZE    = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_REQ = 2'd1,
        ST_WR_REQ = 2'd2
    } sba_state_e;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_cs;
        logic wr_addr;
        logic wr_data;
        logic rd_data;
    } dmi_hit_t;

endpackage

// File: rtl/dbg_sba_decode.sv
module dbg_sba_decode
    import dbg_sba_pkg::*;
(
    input  logic              dmi_valid,
    input  logic              dmi_write,
    input  logic [DMI_AW-1:0] dmi_addr,
    output dmi_hit_t          hit
);

    always_comb begin
        hit = '0;
        if (dmi_valid) begin
            unique case (dmi_addr)
                IDX_CTRL:  hit.wr_ctrl = dmi_write;
                IDX_BUSCS: hit.wr_cs   = dmi_write;
                IDX_ADDR:  hit.wr_addr = dmi_write;
                IDX_DATA: begin
                    hit.wr_data = dmi_write;
                    hit.rd_data = !dmi_write;
                end
                default: hit = '0;
            endcase
        end
    end

endmodule

// File: rtl/dbg_sba_fsm.sv
module dbg_sba_fsm
    import dbg_sba_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [WORD_W-1:0] start_wdata,
    input  logic              mem_ready,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              done_read
);

    sba_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr)      state_d = ST_WR_REQ;
                else if (start_rd) state_d = ST_RD_REQ;
            end
            ST_RD_REQ: if (mem_ready) state_d = ST_IDLE;
            ST_WR_REQ: if (mem_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request payload, captured when a transfer is launched
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && (start_rd || start_wr)) begin
            addr_q  <= start_addr;
            wdata_q <= start_wdata;
        end
    end

    // outputs
    always_comb begin
        mem_valid = 1'b0;
        mem_write = 1'b0;
        unique case (state_q)
            ST_IDLE:   mem_valid = 1'b0;
            ST_RD_REQ: mem_valid = 1'b1;
            ST_WR_REQ: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
            end
            default:   mem_valid = 1'b0;
        endcase
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        busy      = mem_valid;
        done      = mem_valid && mem_ready;
        done_read = (state_q == ST_RD_REQ);
    end

endmodule

// File: rtl/dbg_sba_csr.sv
module dbg_sba_csr
    import dbg_sba_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] STATUS_WORD = 32'h0000_0082
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dmi_hit_t          hit,
    input  logic [DMI_AW-1:0] dmi_addr,
    input  logic [WORD_W-1:0] dmi_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_err,
    input  logic              done_read,
    input  logic [WORD_W-1:0] done_rdata,
    output logic              start_rd,
    output logic              start_wr,
    output logic [ADDR_W-1:0] start_addr,
    output logic [WORD_W-1:0] rd_value
);

    localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(WORD_BYTES);
    localparam logic [6:0]        ASIZE  = 7'(ADDR_W);

    logic              active_q;
    logic              busyerr_q;
    logic              pf_addr_q;
    logic              pf_data_q;
    logic              autoinc_q;
    logic [2:0]        access_q;
    logic [2:0]        err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;

    logic soft_clr, blocked, busy_hit, want_rd, want_wr, size_ok;

    always_comb begin
        soft_clr   = hit.wr_ctrl && !dmi_wdata[0];
        blocked    = busyerr_q || (err_q != ERR_NONE);
        busy_hit   = busy && (hit.wr_addr || hit.wr_data || hit.rd_data);
        want_rd    = !busy && !blocked &&
                     ((hit.wr_addr && pf_addr_q) || (hit.rd_data && pf_data_q));
        want_wr    = !busy && !blocked && hit.wr_data;
        size_ok    = (access_q == SIZE_WORD);
        start_rd   = want_rd && size_ok;
        start_wr   = want_wr && size_ok;
        start_addr = hit.wr_addr ? dmi_wdata[ADDR_W-1:0] : addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            busyerr_q <= 1'b0;
            pf_addr_q <= 1'b0;
            pf_data_q <= 1'b0;
            autoinc_q <= 1'b0;
            access_q  <= SIZE_WORD;
            err_q     <= ERR_NONE;
            addr_q    <= '0;
            data_q    <= '0;
        end else if (soft_clr) begin
            active_q  <= 1'b0;
            busyerr_q <= 1'b0;
            pf_addr_q <= 1'b0;
            pf_data_q <= 1'b0;
            autoinc_q <= 1'b0;
            access_q  <= SIZE_WORD;
            err_q     <= ERR_NONE;
            addr_q    <= '0;
            data_q    <= '0;
        end else begin
            if (hit.wr_ctrl) active_q <= dmi_wdata[0];
            if (hit.wr_cs) begin
                if (dmi_wdata[22]) busyerr_q <= 1'b0;
                pf_addr_q <= dmi_wdata[20];
                access_q  <= dmi_wdata[19:17];
                autoinc_q <= dmi_wdata[16];
                pf_data_q <= dmi_wdata[15];
                err_q     <= err_q & ~dmi_wdata[14:12];
            end
            if (busy_hit) busyerr_q <= 1'b1;
            if ((want_rd || want_wr) && !size_ok) err_q <= ERR_SIZE;
            if (hit.wr_addr && !busy) addr_q <= dmi_wdata[ADDR_W-1:0];
            if (want_wr) data_q <= dmi_wdata;
            if (done) begin
                if (done_err) begin
                    err_q <= ERR_BUS;
                end else begin
                    if (done_read) data_q <= done_rdata;
                    if (autoinc_q) addr_q <= addr_q + STEP;
                end
            end
        end
    end

    always_comb begin
        unique case (dmi_addr)
            IDX_CTRL:   rd_value = {31'd0, active_q};
            IDX_STATUS: rd_value = STATUS_WORD;
            IDX_BUSCS:  rd_value = {FMT_VERSION, 6'd0, busyerr_q, busy, pf_addr_q,
                                    access_q, autoinc_q, pf_data_q, err_q, ASIZE, 5'b00100};
            IDX_ADDR:   rd_value = WORD_W'(addr_q);
            IDX_DATA:   rd_value = data_q;
            default:    rd_value = '0;
        endcase
    end

endmodule

// File: rtl/dbg_sysbus_unit.sv
module dbg_sysbus_unit
    import dbg_sba_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] STATUS_WORD = 32'h0000_0082
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmi_valid,
    input  logic              dmi_write,
    input  logic [5:0]        dmi_addr,
    input  logic [31:0]       dmi_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err
);

    dmi_hit_t          hit;
    logic              start_rd, start_wr, busy, done, done_read;
    logic [ADDR_W-1:0] start_addr;
    logic [WORD_W-1:0] rd_value;

    dbg_sba_decode u_decode (
        .dmi_valid (dmi_valid),
        .dmi_write (dmi_write),
        .dmi_addr  (dmi_addr),
        .hit       (hit)
    );

    dbg_sba_csr #(
        .ADDR_W      (ADDR_W),
        .STATUS_WORD (STATUS_WORD)
    ) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .dmi_addr   (dmi_addr),
        .dmi_wdata  (dmi_wdata),
        .busy       (busy),
        .done       (done),
        .done_err   (mem_err),
        .done_read  (done_read),
        .done_rdata (mem_rdata),
        .start_rd   (start_rd),
        .start_wr   (start_wr),
        .start_addr (start_addr),
        .rd_value   (rd_value)
    );

    dbg_sba_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_rd    (start_rd),
        .start_wr    (start_wr),
        .start_addr  (start_addr),
        .start_wdata (dmi_wdata),
        .mem_ready   (mem_ready),
        .mem_valid   (mem_valid),
        .mem_write   (mem_write),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .busy        (busy),
        .done        (done),
        .done_read   (done_read)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= dmi_valid;
            if (dmi_valid) rsp_rdata <= dmi_write ? '0 : rd_value;
        end
    end

endmodule

// File: rtl/dbg_sysbus_unit_chk.sv
module dbg_sysbus_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dmi_valid,
    input logic              dmi_write,
    input logic [5:0]        dmi_addr,
    input logic [31:0]       dmi_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R3

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid); // R3

    AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) |-> $past(dmi_valid)); // R5

    AST_WRITE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_valid) && mem_write |-> mem_wdata == $past(dmi_wdata) && $past(dmi_write)); // R3

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        dmi_valid |=> rsp_valid); // R12

    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dmi_valid |=> !rsp_valid); // R12

    AST_BUSY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        dmi_valid && !dmi_write && dmi_addr == 6'h38 && mem_valid |=> rsp_rdata[21]); // R7

endmodule

bind dbg_sysbus_unit dbg_sysbus_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dmi_valid (dmi_valid),
    .dmi_write (dmi_write),
    .dmi_addr  (dmi_addr),
    .dmi_wdata (dmi_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_valid (mem_valid),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/dbg_sysbus_unit_tb_top.sv
module dbg_sysbus_unit_tb_top;

    localparam logic [5:0] I_CTRL = 6'h10, I_STAT = 6'h11, I_CS = 6'h38,
                           I_ADDR = 6'h39, I_DATA = 6'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dmi_valid = 1'b0, dmi_write = 1'b0;
    logic [5:0]  dmi_addr = '0;
    logic [31:0] dmi_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int lat = 0, wcnt = 0, acc_cnt = 0, snap = 0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] mem [16];
    logic [31:0] r;
    bit finished = 0;

    always #5 clk = ~clk;

    dbg_sysbus_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .dmi_valid(dmi_valid), .dmi_write(dmi_write), .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    // bus slave model: 64-byte memory, errors above it, answers after lat waits
    always @(negedge clk) begin
        if (mem_valid && !mem_ready) begin
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                acc_cnt++;
                if (mem_addr >= 32'd64) begin
                    mem_err = 1'b1;
                end else begin
                    mem_err = 1'b0;
                    if (mem_write) begin
                        mem[mem_addr[5:2]] = mem_wdata;
                        last_wr_addr = mem_addr;
                    end else begin
                        mem_rdata = mem[mem_addr[5:2]];
                    end
                end
            end else begin
                wcnt++;
            end
        end else if (!mem_valid) begin
            mem_ready = 1'b0;
            mem_err = 1'b0;
            wcnt = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dmi_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        dmi_valid = 1'b1; dmi_write = 1'b1; dmi_addr = a; dmi_wdata = d;
        @(negedge clk);
        dmi_valid = 1'b0; dmi_write = 1'b0;
    endtask

    task automatic dmi_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        dmi_valid = 1'b1; dmi_write = 1'b0; dmi_addr = a;
        @(negedge clk);
        chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        d = rsp_rdata;
        dmi_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (mem_valid) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) mem[k] = 32'h5A00_0000 + 32'(k * k * 3);
        repeat (3) @(negedge clk);
        chk("R12 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R3 reset mem_valid", {31'd0, mem_valid}, 32'd0);
        rst_n = 1'b1;
        dmi_rd(I_CS, r);   chk("R2 reset buscs", r, 32'h2004_0404);
        dmi_rd(I_CTRL, r); chk("R1 reset ctrl", r, 32'd0);
        dmi_wr(I_CTRL, 32'd1);
        dmi_rd(I_CTRL, r); chk("R1 ctrl active", r, 32'd1);
        dmi_rd(I_STAT, r); chk("R1 status word", r, 32'h0000_0082);
        dmi_rd(6'h05, r);  chk("R12 unmapped", r, 32'd0);
        dmi_wr(I_CS, 32'h2005_0404);
        dmi_rd(I_CS, r);   chk("R2 buscs autoinc", r, 32'h2005_0404);

        // write bursts with auto-increment across latencies
        for (int l = 0; l < 4; l++) begin
            lat = l;
            dmi_wr(I_ADDR, 32'd0);
            for (int j = 0; j < 5; j++) begin
                dmi_wr(I_DATA, 32'hC0DE_0000 | 32'(l << 8) | 32'(j));
                wait_idle();
                chk("R3 stored word", mem[j], 32'hC0DE_0000 | 32'(l << 8) | 32'(j));
                chk("R4 write address", last_wr_addr, 32'(4 * j));
            end
            dmi_rd(I_ADDR, r); chk("R4 address after burst", r, 32'd20);
        end

        // no auto-increment
        dmi_wr(I_CS, 32'h2004_0404);
        dmi_wr(I_ADDR, 32'd8);
        dmi_wr(I_DATA, 32'h0000_1234); wait_idle();
        dmi_wr(I_DATA, 32'h0000_5678); wait_idle();
        dmi_rd(I_ADDR, r); chk("R4 no-inc address", r, 32'd8);
        chk("R4 no-inc overwrite", mem[2], 32'h0000_5678);

        // prefetch reads
        for (int k = 0; k < 16; k++) mem[k] = 32'h5A00_0000 + 32'(k * k * 3);
        dmi_wr(I_CS, 32'h2015_8404);
        dmi_rd(I_CS, r); chk("R2 buscs prefetch", r, 32'h2015_8404);
        for (int l = 0; l < 4; l++) begin
            lat = l;
            snap = acc_cnt;
            dmi_wr(I_ADDR, 32'(4 * l));
            wait_idle();
            chk("R5 read on address", 32'(acc_cnt - snap), 32'd1);
            dmi_rd(I_DATA, r);
            chk("R5 fetched word", r, mem[l]);
            wait_idle();
            for (int j = 1; j < 5; j++) begin
                dmi_rd(I_DATA, r);
                chk("R6 streamed word", r, mem[l + j]);
                wait_idle();
            end
            dmi_rd(I_ADDR, r); chk("R6 address after stream", r, 32'(4 * l + 24));
        end

        // busy and busy-error
        dmi_wr(I_CS, 32'h2005_0404);
        lat = 6;
        dmi_wr(I_ADDR, 32'h20);
        dmi_wr(I_DATA, 32'hAAAA_0001);
        dmi_rd(I_CS, r); chk("R7 busy bit", {31'd0, r[21]}, 32'd1);
        dmi_wr(I_DATA, 32'hBBBB_0002);
        wait_idle();
        dmi_rd(I_CS, r); chk("R8 busyerror set", r, 32'h2045_0404);
        chk("R8 second write dropped", mem[8], 32'hAAAA_0001);
        dmi_rd(I_ADDR, r); chk("R8 single increment", r, 32'h24);
        snap = acc_cnt;
        dmi_wr(I_DATA, 32'hCCCC_0003); wait_idle();
        chk("R8 blocked while flagged", 32'(acc_cnt - snap), 32'd0);
        dmi_wr(I_CS, 32'h2045_0404);
        dmi_rd(I_CS, r); chk("R8 busyerror cleared", r, 32'h2005_0404);

        // bus error
        lat = 1;
        dmi_wr(I_ADDR, 32'h100);
        dmi_wr(I_DATA, 32'hDEAD_0000); wait_idle();
        dmi_rd(I_CS, r);   chk("R9 error code", r, 32'h2005_2404);
        dmi_rd(I_ADDR, r); chk("R9 address kept", r, 32'h100);
        dmi_wr(I_ADDR, 32'd0);
        snap = acc_cnt;
        dmi_wr(I_DATA, 32'h0000_0001); wait_idle();
        chk("R9 blocked by error", 32'(acc_cnt - snap), 32'd0);
        dmi_wr(I_CS, 32'h2005_7404);
        dmi_rd(I_CS, r); chk("R9 error cleared", r, 32'h2005_0404);
        dmi_wr(I_DATA, 32'h0000_0077); wait_idle();
        chk("R9 recovered write", mem[0], 32'h0000_0077);

        // unsupported access size
        dmi_wr(I_CS, 32'h2003_0404);
        snap = acc_cnt;
        dmi_wr(I_DATA, 32'h0000_0099); wait_idle();
        chk("R10 no bus access", 32'(acc_cnt - snap), 32'd0);
        dmi_rd(I_CS, r); chk("R10 size error", r, 32'h2003_4404);

        // soft reset through control
        dmi_wr(I_CTRL, 32'd0);
        dmi_rd(I_CS, r);   chk("R11 buscs reset", r, 32'h2004_0404);
        dmi_rd(I_ADDR, r); chk("R11 address reset", r, 32'd0);
        dmi_rd(I_DATA, r); chk("R11 data reset", r, 32'd0);
        dmi_rd(I_CTRL, r); chk("R11 ctrl reset", r, 32'd0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule